// File: doc/BRIEF.md
# Burst-Capable AXI4 RAM Target

This block is an AXI4 subordinate that fronts a word-organised on-chip RAM. It accepts incrementing read and write bursts on the five independent channels. It keeps accepted read commands and accepted write commands in two small in-order queues, and it serves each queue strictly oldest-first. Reads return the command's ID on every beat. Writes merge each data beat into memory under its byte strobes. Each write burst ends with one OKAY response that carries the command's ID. The response can be held back by a run-time cycle count.

A mode input chooses how write address and write data are paired. In split mode, addresses queue up on their own, and data beats are applied to the oldest queued address. In coupled mode, the block waits until an address and data are offered together, absorbs every data beat, and only then acknowledges the address with a single-cycle ready pulse. The response follows after that. A sticky flag records any accepted command whose burst would run past the end of a 4 KB page. The transfer itself still runs to completion.

Top module: `axi_burst_ram`

## Requirements
- R1: Immediately after reset, arready and awready are 1, rvalid and bvalid are 0, and page_cross_err is 0.
- R2: At most QDEPTH (default 8) read commands and QDEPTH write commands are outstanding. A read command stays outstanding until its last R beat is taken, and a write command until its B handshake. arready or awready (split mode) is 0 while its queue holds QDEPTH commands.
- R3: Read bursts return in the order their AR handshakes occurred. Each burst gives len+1 beats, every beat carries that command's arid, rlast is 1 on the final beat only, and rresp is 0.
- R4: Beat i of a burst starting at byte address A uses memory word ((A / BYTES) + i) modulo MEM_WORDS, where BYTES = DATA_W/8 and the address is taken as word aligned.
- R5: On a W beat, byte lane k (data bits [8k+7:8k], the lowest-addressed byte being lane 0) is written only when wstrb bit k is 1. The other lanes keep their old contents.
- R6: While rvalid is 1 and rready is 0, rvalid stays 1 and rdata, rid and rlast do not change.
- R7: Each write burst produces exactly one B response with the command's ID and bresp 0. bvalid and bid hold until bready is 1.
- R8: In split mode, bvalid is high after exactly resp_delay clock edges following the edge that takes the burst's final W beat. A resp_delay of 0 means it is high right after that edge.
- R9: In coupled mode, awready stays 0 until every W beat of the burst has been taken, is then 1 for exactly one cycle, and the B response follows.
- R10: In split mode, W beats are written at the address of the oldest queued write command, and that command keeps its queue slot until its B handshake completes.
- R11: page_cross_err becomes 1 and stays 1 once an AR or AW handshake has (len+1)*BYTES + (addr mod 4096) greater than 4096. A burst that ends exactly at the page end does not set it, and the flagged burst still completes normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| coupled_mode | input | 1 | 1: coupled write handling, 0: split (change only when idle) |
| resp_delay | input | DLY_W | Cycles inserted before bvalid |
| arvalid | input | 1 | Read command valid |
| arready | output | 1 | Read command ready |
| araddr | input | ADDR_W | Read byte address |
| arlen | input | LEN_W | Read beats minus one |
| arid | input | ID_W | Read transaction ID |
| rvalid | output | 1 | Read data valid |
| rready | input | 1 | Read data ready |
| rdata | output | DATA_W | Read data |
| rid | output | ID_W | Read ID |
| rlast | output | 1 | Final read beat |
| rresp | output | 2 | Read response (always OKAY) |
| awvalid | input | 1 | Write command valid |
| awready | output | 1 | Write command ready |
| awaddr | input | ADDR_W | Write byte address |
| awlen | input | LEN_W | Write beats minus one |
| awid | input | ID_W | Write transaction ID |
| wvalid | input | 1 | Write data valid |
| wready | output | 1 | Write data ready |
| wdata | input | DATA_W | Write data |
| wstrb | input | DATA_W/8 | Byte strobes |
| bvalid | output | 1 | Write response valid |
| bready | input | 1 | Write response ready |
| bid | output | ID_W | Write response ID |
| bresp | output | 2 | Write response (always OKAY) |
| page_cross_err | output | 1 | Sticky 4 KB crossing flag |

## Verification
The hardest state to reach is a completely full command queue. With the default depth, only a master that keeps issuing commands while holding back the drain side can get there. The stimulus reaches it by keeping rready low while nine read commands of mixed length are offered, and by offering nine write addresses before any data. It then drains the queues and confirms the stall, the ordering, and that the freed write slot reappears only at the B handshake. A second hard case is the exact page-end burst, which has to be told apart from one that overruns by a single beat. Two reads placed on either side of that edge cover it.

// File: rtl/axi_ram_pkg.sv
package axi_ram_pkg;

  typedef enum logic [1:0] {RD_IDLE, RD_FETCH, RD_SHOW} rd_state_t;

  typedef enum logic [2:0] {WR_IDLE, WR_DATA, WR_ACK, WR_WAIT, WR_RESP} wr_state_t;

  localparam int unsigned PAGE_BYTES = 4096;

  // True when a burst starting at addr with len+1 beats runs past the page end.
  function automatic logic crosses_page(input logic [63:0] addr,
                                        input logic [15:0] len,
                                        input int unsigned bytes);
    int unsigned span;
    span = (int'(len) + 1) * bytes + int'(addr[11:0]);
    return span > PAGE_BYTES;
  endfunction

endpackage

// File: rtl/axi_ram_cmd_fifo.sv
module axi_ram_cmd_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         full,
  output logic         empty
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0] slots [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [PW:0]   cnt;

  assign full  = (cnt == (PW+1)'(DEPTH));
  assign empty = (cnt == '0);
  assign dout  = slots[rp];

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push && !full) slots[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push && !full) wp <= bump(wp);
      if (pop && !empty) rp <= bump(rp);
      case ({push && !full, pop && !empty})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/axi_ram_rd_engine.sv
module axi_ram_rd_engine
  import axi_ram_pkg::*;
#(
  parameter int IDX_W = 8,
  parameter int LEN_W = 8,
  parameter int ID_W  = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_valid,
  input  logic [IDX_W-1:0] cmd_idx,
  input  logic [LEN_W-1:0] cmd_len,
  input  logic [ID_W-1:0]  cmd_id,
  output logic             cmd_pop,
  output logic             mem_re,
  output logic [IDX_W-1:0] mem_ridx,
  input  logic             rready,
  output logic             rvalid,
  output logic [ID_W-1:0]  rid,
  output logic             rlast
);
  rd_state_t        st;
  logic [IDX_W-1:0] idx;
  logic [LEN_W-1:0] beat;

  assign rvalid   = (st == RD_SHOW);
  assign rid      = cmd_id;
  assign rlast    = (beat == cmd_len);
  assign mem_re   = (st == RD_FETCH);
  assign mem_ridx = idx;
  assign cmd_pop  = rvalid && rready && rlast;

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= RD_IDLE;
      idx  <= '0;
      beat <= '0;
    end else begin
      case (st)
        RD_IDLE: if (cmd_valid) begin
          idx  <= cmd_idx;
          beat <= '0;
          st   <= RD_FETCH;
        end
        RD_FETCH: st <= RD_SHOW;
        RD_SHOW: if (rready) begin
          if (rlast) st <= RD_IDLE;
          else begin
            idx  <= idx + 1'b1;
            beat <= beat + 1'b1;
            st   <= RD_FETCH;
          end
        end
        default: st <= RD_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/axi_ram_wr_engine.sv
module axi_ram_wr_engine
  import axi_ram_pkg::*;
#(
  parameter int IDX_W = 8,
  parameter int LEN_W = 8,
  parameter int ID_W  = 4,
  parameter int DLY_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             coupled,
  input  logic [DLY_W-1:0] resp_delay,
  input  logic             q_valid,
  input  logic [IDX_W-1:0] q_idx,
  input  logic [LEN_W-1:0] q_len,
  input  logic [ID_W-1:0]  q_id,
  output logic             q_pop,
  input  logic             awvalid,
  input  logic [IDX_W-1:0] aw_idx,
  input  logic [LEN_W-1:0] aw_len,
  input  logic [ID_W-1:0]  aw_id,
  output logic             aw_pulse,
  input  logic             wvalid,
  output logic             wready,
  output logic             mem_we,
  output logic [IDX_W-1:0] mem_widx,
  input  logic             bready,
  output logic             bvalid,
  output logic [ID_W-1:0]  bid
);
  wr_state_t        st;
  logic [IDX_W-1:0] idx;
  logic [LEN_W-1:0] beat, len_q;
  logic [ID_W-1:0]  id_q;
  logic [DLY_W-1:0] cnt;
  logic             via_q;

  assign wready   = (st == WR_DATA);
  assign mem_we   = wready && wvalid;
  assign mem_widx = idx;
  assign aw_pulse = (st == WR_ACK);
  assign bvalid   = (st == WR_RESP);
  assign bid      = id_q;
  assign q_pop    = bvalid && bready && via_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= WR_IDLE;
      idx   <= '0;
      beat  <= '0;
      len_q <= '0;
      id_q  <= '0;
      cnt   <= '0;
      via_q <= 1'b0;
    end else begin
      case (st)
        WR_IDLE: begin
          beat <= '0;
          if (coupled) begin
            if (awvalid && wvalid) begin
              idx <= aw_idx; len_q <= aw_len; id_q <= aw_id;
              via_q <= 1'b0;
              st <= WR_DATA;
            end
          end else if (q_valid) begin
            idx <= q_idx; len_q <= q_len; id_q <= q_id;
            via_q <= 1'b1;
            st <= WR_DATA;
          end
        end
        WR_DATA: if (wvalid) begin
          idx  <= idx + 1'b1;
          beat <= beat + 1'b1;
          if (beat == len_q) begin
            if (!via_q) st <= WR_ACK;
            else if (resp_delay == '0) st <= WR_RESP;
            else begin cnt <= resp_delay; st <= WR_WAIT; end
          end
        end
        WR_ACK: begin
          if (resp_delay == '0) st <= WR_RESP;
          else begin cnt <= resp_delay; st <= WR_WAIT; end
        end
        WR_WAIT: begin
          cnt <= cnt - 1'b1;
          if (cnt == DLY_W'(1)) st <= WR_RESP;
        end
        WR_RESP: if (bready) st <= WR_IDLE;
        default: st <= WR_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/axi_burst_ram.sv
module axi_burst_ram
  import axi_ram_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 32,
  parameter int ID_W      = 4,
  parameter int LEN_W     = 8,
  parameter int MEM_WORDS = 256,
  parameter int QDEPTH    = 8,
  parameter int DLY_W     = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              coupled_mode,
  input  logic [DLY_W-1:0]  resp_delay,
  input  logic              arvalid,
  output logic              arready,
  input  logic [ADDR_W-1:0] araddr,
  input  logic [LEN_W-1:0]  arlen,
  input  logic [ID_W-1:0]   arid,
  output logic              rvalid,
  input  logic              rready,
  output logic [DATA_W-1:0] rdata,
  output logic [ID_W-1:0]   rid,
  output logic              rlast,
  output logic [1:0]        rresp,
  input  logic              awvalid,
  output logic              awready,
  input  logic [ADDR_W-1:0] awaddr,
  input  logic [LEN_W-1:0]  awlen,
  input  logic [ID_W-1:0]   awid,
  input  logic              wvalid,
  output logic              wready,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W/8-1:0] wstrb,
  output logic              bvalid,
  input  logic              bready,
  output logic [ID_W-1:0]   bid,
  output logic [1:0]        bresp,
  output logic              page_cross_err
);
  localparam int BYTES = DATA_W / 8;
  localparam int LSB   = $clog2(BYTES);
  localparam int IDX_W = $clog2(MEM_WORDS);
  localparam int CMD_W = IDX_W + LEN_W + ID_W;

  // Read command queue
  logic             ar_hs, rq_full, rq_empty, rq_pop;
  logic [CMD_W-1:0] rq_dout;
  assign arready = !rq_full;
  assign ar_hs   = arvalid && arready;

  axi_ram_cmd_fifo #(.W(CMD_W), .DEPTH(QDEPTH)) rq_i (
    .clk(clk), .rst(rst), .push(ar_hs),
    .din({araddr[LSB +: IDX_W], arlen, arid}),
    .pop(rq_pop), .dout(rq_dout), .full(rq_full), .empty(rq_empty));

  // Write command queue (split mode only)
  logic             aw_hs, wq_full, wq_empty, wq_pop, aw_pulse;
  logic [CMD_W-1:0] wq_dout;
  assign awready = coupled_mode ? aw_pulse : !wq_full;
  assign aw_hs   = awvalid && awready;

  axi_ram_cmd_fifo #(.W(CMD_W), .DEPTH(QDEPTH)) wq_i (
    .clk(clk), .rst(rst), .push(aw_hs && !coupled_mode),
    .din({awaddr[LSB +: IDX_W], awlen, awid}),
    .pop(wq_pop), .dout(wq_dout), .full(wq_full), .empty(wq_empty));

  // Engines
  logic             mem_re, mem_we;
  logic [IDX_W-1:0] mem_ridx, mem_widx;

  axi_ram_rd_engine #(.IDX_W(IDX_W), .LEN_W(LEN_W), .ID_W(ID_W)) rd_i (
    .clk(clk), .rst(rst), .cmd_valid(!rq_empty),
    .cmd_idx(rq_dout[CMD_W-1 -: IDX_W]),
    .cmd_len(rq_dout[ID_W +: LEN_W]),
    .cmd_id(rq_dout[ID_W-1:0]),
    .cmd_pop(rq_pop), .mem_re(mem_re), .mem_ridx(mem_ridx),
    .rready(rready), .rvalid(rvalid), .rid(rid), .rlast(rlast));

  axi_ram_wr_engine #(.IDX_W(IDX_W), .LEN_W(LEN_W), .ID_W(ID_W), .DLY_W(DLY_W)) wr_i (
    .clk(clk), .rst(rst), .coupled(coupled_mode), .resp_delay(resp_delay),
    .q_valid(!wq_empty),
    .q_idx(wq_dout[CMD_W-1 -: IDX_W]),
    .q_len(wq_dout[ID_W +: LEN_W]),
    .q_id(wq_dout[ID_W-1:0]),
    .q_pop(wq_pop),
    .awvalid(awvalid), .aw_idx(awaddr[LSB +: IDX_W]), .aw_len(awlen), .aw_id(awid),
    .aw_pulse(aw_pulse), .wvalid(wvalid), .wready(wready),
    .mem_we(mem_we), .mem_widx(mem_widx),
    .bready(bready), .bvalid(bvalid), .bid(bid));

  // Byte-enabled RAM, one write port and one registered read port
  logic [DATA_W-1:0] ram [MEM_WORDS];
  logic [DATA_W-1:0] rd_q;

  always_ff @(posedge clk) begin
    for (int k = 0; k < BYTES; k++) begin
      if (mem_we && wstrb[k]) ram[mem_widx][8*k +: 8] <= wdata[8*k +: 8];
    end
  end

  always_ff @(posedge clk) begin
    if (mem_re) rd_q <= ram[mem_ridx];
  end

  assign rdata = rd_q;
  assign rresp = 2'b00;
  assign bresp = 2'b00;

  // Sticky page-crossing flag
  always_ff @(posedge clk) begin
    if (rst) page_cross_err <= 1'b0;
    else if ((ar_hs && crosses_page(64'(araddr), 16'(arlen), BYTES)) ||
             (aw_hs && crosses_page(64'(awaddr), 16'(awlen), BYTES)))
      page_cross_err <= 1'b1;
  end
endmodule

// File: rtl/axi_burst_ram_chk.sv
module axi_burst_ram_chk #(
  parameter int DATA_W = 32,
  parameter int ID_W   = 4,
  parameter int QDEPTH = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              coupled_mode,
  input logic              arvalid,
  input logic              arready,
  input logic              awvalid,
  input logic              awready,
  input logic              rvalid,
  input logic              rready,
  input logic              rlast,
  input logic [DATA_W-1:0] rdata,
  input logic [ID_W-1:0]   rid,
  input logic [1:0]        rresp,
  input logic              wready,
  input logic              bvalid,
  input logic              bready,
  input logic [ID_W-1:0]   bid,
  input logic [1:0]        bresp,
  input logic              page_cross_err
);
  localparam int CW = $clog2(QDEPTH + 2) + 1;
  logic [CW-1:0] rd_out, wr_out;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_out <= '0;
      wr_out <= '0;
    end else begin
      rd_out <= rd_out + CW'(arvalid && arready) - CW'(rvalid && rready && rlast);
      wr_out <= wr_out + CW'(awvalid && awready) - CW'(bvalid && bready);
    end
  end

  a_r2_rd_limit: assert property (@(posedge clk) disable iff (rst)
    rd_out <= CW'(QDEPTH));
  a_r2_wr_limit: assert property (@(posedge clk) disable iff (rst)
    wr_out <= CW'(QDEPTH));
  a_r3_rresp_okay: assert property (@(posedge clk) disable iff (rst)
    rvalid |-> rresp == 2'b00);
  a_r6_r_hold: assert property (@(posedge clk) disable iff (rst)
    (rvalid && !rready) |=> (rvalid && $stable(rdata) && $stable(rid) && $stable(rlast)));
  a_r7_b_hold: assert property (@(posedge clk) disable iff (rst)
    (bvalid && !bready) |=> (bvalid && $stable(bid)));
  a_r7_bresp_okay: assert property (@(posedge clk) disable iff (rst)
    bvalid |-> bresp == 2'b00);
  a_r9_aw_pulse: assert property (@(posedge clk) disable iff (rst)
    (coupled_mode && awready) |=> !awready);
  a_r9_no_data_at_ack: assert property (@(posedge clk) disable iff (rst)
    (coupled_mode && awready) |-> !wready);
  a_r11_sticky: assert property (@(posedge clk) disable iff (rst)
    page_cross_err |=> page_cross_err);
endmodule

bind axi_burst_ram axi_burst_ram_chk #(.DATA_W(DATA_W), .ID_W(ID_W), .QDEPTH(QDEPTH)) chk_i (
  .clk(clk), .rst(rst), .coupled_mode(coupled_mode),
  .arvalid(arvalid), .arready(arready), .awvalid(awvalid), .awready(awready),
  .rvalid(rvalid), .rready(rready), .rlast(rlast), .rdata(rdata), .rid(rid),
  .rresp(rresp), .wready(wready), .bvalid(bvalid), .bready(bready), .bid(bid),
  .bresp(bresp), .page_cross_err(page_cross_err));

// File: tb/axi_burst_ram_tb.sv
`timescale 1ns/1ps
module axi_burst_ram_tb_top;
  localparam int AW = 16, DW = 32, IW = 4, LW = 8, WORDS = 256, QD = 8, DLW = 4;
  localparam int NB = DW / 8;

  logic clk = 1'b0, rst = 1'b1;
  logic coupled_mode = 1'b0;
  logic [DLW-1:0] resp_delay = '0;
  logic arvalid = 0, arready; logic [AW-1:0] araddr = '0; logic [LW-1:0] arlen = '0; logic [IW-1:0] arid = '0;
  logic rvalid, rready = 0, rlast; logic [DW-1:0] rdata; logic [IW-1:0] rid; logic [1:0] rresp;
  logic awvalid = 0, awready; logic [AW-1:0] awaddr = '0; logic [LW-1:0] awlen = '0; logic [IW-1:0] awid = '0;
  logic wvalid = 0, wready; logic [DW-1:0] wdata = '0; logic [NB-1:0] wstrb = '0;
  logic bvalid, bready = 0; logic [IW-1:0] bid; logic [1:0] bresp;
  logic page_cross_err;

  always #2.5 clk = ~clk;

  axi_burst_ram #(.ADDR_W(AW), .DATA_W(DW), .ID_W(IW), .LEN_W(LW), .MEM_WORDS(WORDS),
                  .QDEPTH(QD), .DLY_W(DLW)) dut_i (.*);

  int checks = 0, errors = 0;
  logic [DW-1:0] ref_mem [WORDS];

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] pat(input int seed, input int i);
    return {8'(seed), 8'(i), ~8'(seed), 8'(i) ^ 8'h5A};
  endfunction

  task automatic ar_send(input int addr, input int len, input int id, output bit ok);
    ok = 0;
    @(negedge clk);
    araddr = AW'(addr); arlen = LW'(len); arid = IW'(id); arvalid = 1;
    for (int t = 0; t < 20; t++) begin
      if (arready) begin ok = 1; break; end
      @(negedge clk);
    end
    if (ok) @(posedge clk);
    #1 arvalid = 0;
  endtask

  task automatic aw_send(input int addr, input int len, input int id, output bit ok);
    ok = 0;
    @(negedge clk);
    awaddr = AW'(addr); awlen = LW'(len); awid = IW'(id); awvalid = 1;
    for (int t = 0; t < 20; t++) begin
      if (awready) begin ok = 1; break; end
      @(negedge clk);
    end
    if (ok) @(posedge clk);
    #1 awvalid = 0;
  endtask

  // strb_mode 0: all lanes; 1: lane mask = beat index
  task automatic w_beats(input int widx, input int len, input int seed, input int strb_mode, input bit cpl);
    for (int i = 0; i <= len; i++) begin
      @(negedge clk);
      wdata = pat(seed, i);
      wstrb = (strb_mode == 0) ? '1 : NB'(i);
      wvalid = 1;
      while (!wready) begin
        if (cpl) chk(awready == 0, "R9 awready early", awready, 0);
        @(negedge clk);
      end
      if (cpl) chk(awready == 0, "R9 awready during data", awready, 0);
      @(posedge clk);
      for (int k = 0; k < NB; k++)
        if (wstrb[k]) ref_mem[(widx + i) % WORDS][8*k +: 8] = wdata[8*k +: 8];
      #1 wvalid = 0;
    end
  endtask

  task automatic b_wait(input int id, input int hold);
    @(negedge clk);
    while (!bvalid) @(negedge clk);
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      chk(bvalid == 1, "R7 bvalid held", bvalid, 1);
    end
    chk(bid == IW'(id), "R7 bid", bid, id);
    chk(bresp == 0, "R7 bresp", bresp, 0);
    bready = 1;
    @(posedge clk);
    #1 bready = 0;
    @(negedge clk);
    chk(bvalid == 0, "R7 single response", bvalid, 0);
  endtask

  task automatic r_collect(input int widx, input int len, input int id, input bit stall);
    int beat = 0, cyc = 0;
    bit held = 0;
    logic [DW-1:0] sd; logic [IW-1:0] si; logic sl;
    while (beat <= len) begin
      @(negedge clk);
      rready = stall ? ((cyc % 3) != 2) : 1'b1;
      cyc++;
      if (rvalid) begin
        if (held) begin
          chk(rdata == sd && rid == si && rlast == sl, "R6 stable while stalled", rdata, sd);
          held = 0;
        end
        if (rready) begin
          chk(rdata == ref_mem[(widx + beat) % WORDS], "R4/R5 beat data", rdata, ref_mem[(widx + beat) % WORDS]);
          chk(rid == IW'(id), "R3 rid", rid, id);
          chk(rlast == (beat == len), "R3 rlast", rlast, beat == len);
          chk(rresp == 0, "R3 rresp", rresp, 0);
          beat++;
        end else begin
          sd = rdata; si = rid; sl = rlast; held = 1;
        end
      end
    end
    @(posedge clk);
    #1 rready = 0;
  endtask

  bit done = 0;
  initial begin
    for (int c = 0; c < 150000 && !done; c++) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    bit ok;
    int n;
    repeat (4) @(posedge clk);
    #1 rst = 0;
    @(negedge clk);
    // R1
    chk(arready == 1, "R1 arready", arready, 1);
    chk(awready == 1, "R1 awready", awready, 1);
    chk(rvalid == 0, "R1 rvalid", rvalid, 0);
    chk(bvalid == 0, "R1 bvalid", bvalid, 0);
    chk(page_cross_err == 0, "R1 flag", page_cross_err, 0);

    // Fill whole RAM with one long burst (R4)
    aw_send(0, 255, 1, ok);
    w_beats(0, 255, 7, 0, 0);
    b_wait(1, 0);

    // Strobe sweep over all 16 lane masks (R5)
    aw_send(16 * NB, 15, 2, ok);
    w_beats(16, 15, 9, 1, 0);
    b_wait(2, 3);
    ar_send(0, 31, 3, ok);
    r_collect(0, 31, 3, 1);

    // Response delay sweep (R8)
    for (int d = 0; d <= 5; d++) begin
      resp_delay = DLW'(d);
      aw_send((40 + 2 * d) * NB, 1, d, ok);
      w_beats(40 + 2 * d, 1, 20 + d, 0, 0);
      n = 0;
      @(negedge clk);
      while (!bvalid && n < 50) begin @(negedge clk); n++; end
      chk(n == d, "R8 delay edges", n, d);
      b_wait(d, 0);
    end
    resp_delay = 0;

    // Read queue limit and ordering (R2, R3)
    rready = 0;
    for (int i = 0; i < 9; i++) begin
      ar_send(8 * i * NB, i % 4, i + 1, ok);
      chk(ok == (i < 8), "R2 read queue stall", ok, i < 8);
    end
    for (int i = 0; i < 8; i++) r_collect(8 * i, i % 4, i + 1, i[0]);

    // Write queue limit, oldest-first, slot freed at B (R2, R10)
    for (int i = 0; i < 9; i++) begin
      aw_send((60 + 4 * i) * NB, i % 3, 15 - i, ok);
      chk(ok == (i < 8), "R2 write queue stall", ok, i < 8);
    end
    for (int i = 0; i < 8; i++) begin
      w_beats(60 + 4 * i, i % 3, 40 + i, 0, 0);
      if (i == 0) begin
        @(negedge clk);
        chk(awready == 0, "R10 slot held until B", awready, 0);
      end
      b_wait(15 - i, 0);
      if (i == 0) chk(awready == 1, "R10 slot freed at B", awready, 1);
    end
    ar_send(60 * NB, 31, 9, ok);
    r_collect(60, 31, 9, 0);

    // Coupled mode (R9)
    coupled_mode = 1;
    resp_delay = 2;
    for (int j = 0; j < 3; j++) begin
      n = (j == 0) ? 0 : (j == 1 ? 3 : 5);
      #1 awaddr = AW'((100 + 8 * j) * NB); awlen = LW'(n); awid = IW'(5 + j); awvalid = 1;
      w_beats(100 + 8 * j, n, 60 + j, 0, 1);
      @(negedge clk);
      chk(awready == 1, "R9 awready after last beat", awready, 1);
      @(posedge clk);
      #1 awvalid = 0;
      @(negedge clk);
      chk(awready == 0, "R9 one-cycle pulse", awready, 0);
      b_wait(5 + j, 1);
    end
    coupled_mode = 0;
    resp_delay = 0;
    ar_send(100 * NB, 23, 4, ok);
    r_collect(100, 23, 4, 1);

    // Page crossing (R11)
    chk(page_cross_err == 0, "R11 flag clear", page_cross_err, 0);
    ar_send(16'h0FF0, 3, 6, ok);
    r_collect((16'h0FF0 / NB) % WORDS, 3, 6, 0);
    chk(page_cross_err == 0, "R11 exact page end", page_cross_err, 0);
    ar_send(16'h0FF8, 3, 7, ok);
    r_collect((16'h0FF8 / NB) % WORDS, 3, 7, 0);
    chk(page_cross_err == 1, "R11 overrun flagged", page_cross_err, 1);
    aw_send(0, 0, 8, ok);
    w_beats(0, 0, 90, 0, 0);
    b_wait(8, 0);
    chk(page_cross_err == 1, "R11 sticky", page_cross_err, 1);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule